// File: doc/BRIEF.md
# SCL Low-Time Guard

This block watches the clock line of a two-wire SMBus-style bus and times how long it stays low. It does not care who holds the line down: the master driving a normal low phase and a slave stretching the clock both count against the same budget. The raw line is first made safe for the system clock domain by a short synchronizer chain. A filter then passes a new level only after every one of its recent samples agrees.

A programmable prescaler turns the system clock into a time-base tick, nominally 1 µs. A saturating counter counts ticks for as long as the filtered line is low and the block is enabled. When the count reaches the programmed limit (35000 ticks gives the 35 ms bus budget), the block raises a live timeout flag. It also emits a single one-cycle reset request for the attached protocol engine and sets a sticky status bit that stays set until it is cleared. A warning flag goes high earlier, once the line has been low longer than the low phase of the slowest legal clock (10 kHz, a 100 µs period) allows.

Top module: `scl_guard`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `timeout_o`, `bus_reset_o`, `sticky_o` and `warn_o` are all 0.
- R2: A level on `scl_raw` that lasts fewer than FILT_LEN (3) clock cycles has no effect. A level that lasts at least FILT_LEN cycles reaches the filtered line SYNC_STAGES+FILT_LEN+1 (6) cycles after it is applied, and stays there for as many cycles as it lasted on `scl_raw`.
- R3: While enabled and low, the counter advances by one per tick, and a tick occurs every `prescale_div`+1 clock cycles. With `prescale_div`=0, a filtered low of D cycles produces a timeout exactly when D > `limit`.
- R4: With `prescale_div`=0, `timeout_o` goes to 1 exactly `limit`+7 cycles after `scl_raw` falls, stays 1 while the line is held low, and returns to 0 after the line goes high.
- R5: `bus_reset_o` is high for exactly one cycle per low period that crosses the limit, in the same cycle that `timeout_o` first rises.
- R6: `sticky_o` is set together with the reset pulse. It stays 1 through any later bus activity until `clr_sticky` is pulsed, and it is 0 in the cycle after the clear.
- R7: `warn_o` goes to 1 exactly WARN_TICKS+7 cycles after `scl_raw` falls (with `prescale_div`=0), and returns to 0 after the line goes high.
- R8: A high level on the filtered line clears the count, so two separate low periods that are each shorter than the limit never add up to a timeout.
- R9: While `en` is 0, the count and the tick are held at zero, and no flag, pulse or sticky bit is raised, however long the line stays low.
- R10: The counter saturates at its maximum value instead of wrapping. With `limit` equal to that maximum, `timeout_o` stays 1 for as long as the line is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables ticking and low-time counting |
| scl_raw | input | 1 | Asynchronous bus clock line as seen at the pad |
| prescale_div | input | PRE_W | A tick occurs every prescale_div+1 clock cycles |
| limit | input | CNT_W | Timeout threshold in ticks (35000 for 35 ms at 1 µs) |
| clr_sticky | input | 1 | Clears the sticky timeout status |
| timeout_o | output | 1 | Live flag: the line has been low past the limit |
| bus_reset_o | output | 1 | One-cycle reset request per timeout event |
| sticky_o | output | 1 | Latched timeout status |
| warn_o | output | 1 | Line has been low longer than the minimum-frequency low phase |

## Verification
A falling edge on `scl_raw` takes six cycles to reach the filtered line: two synchronizer flops, three filter samples and the filter register. The counter then needs `limit` ticks and the flag register adds one more cycle. With a divide of zero, `timeout_o`, `bus_reset_o` and `sticky_o` therefore change `limit`+7 cycles after the raw fall, and `warn_o` changes WARN_TICKS+7 cycles after it. The bench drives inputs and samples outputs on falling clock edges, and counts edges from the drive. It checks each of these outputs one cycle before the cycle it is due and again in that cycle. Checks that are not tied to a cycle (random low lengths, the prescaler, disable, saturation) are read only after the line has been high long enough for every stage to settle.

// File: rtl/scl_guard_pkg.sv
package scl_guard_pkg;

  // Level of the bus clock line when nothing drives it.
  localparam logic SCL_IDLE_LVL = 1'b1;

  // Registered results of the low-time counter.
  typedef struct packed {
    logic timeout;
    logic bus_reset;
    logic sticky;
    logic warn;
  } guard_flags_t;

endpackage

// File: rtl/scl_guard_filter.sv
module scl_guard_filter
  import scl_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  output logic scl_filt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   filt_q;
  logic                   sync_out;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {SYNC_STAGES{SCL_IDLE_LVL}};
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], scl_in};
  end

  assign sync_out = sync_q[SYNC_STAGES-1];

  generate
    if (FILT_LEN > 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) hist_q <= {FILT_LEN{SCL_IDLE_LVL}};
        else     hist_q <= {hist_q[FILT_LEN-2:0], sync_out};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) hist_q <= {FILT_LEN{SCL_IDLE_LVL}};
        else     hist_q <= sync_out;
      end
    end
  endgenerate

  // A new level passes only once every sample in the window agrees.
  always_ff @(posedge clk) begin
    if (rst)                           filt_q <= SCL_IDLE_LVL;
    else if (hist_q == {FILT_LEN{1'b0}}) filt_q <= 1'b0;
    else if (hist_q == {FILT_LEN{1'b1}}) filt_q <= 1'b1;
  end

  assign scl_filt = filt_q;

  // R2: a window with mixed samples never moves the filtered level
  p_mixed_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (hist_q != {FILT_LEN{1'b0}} && hist_q != {FILT_LEN{1'b1}}) |=> $stable(filt_q));

endmodule

// File: rtl/scl_guard_tick.sv
module scl_guard_tick #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PRE_W-1:0] prescale_div,
  output logic             tick
);

  logic [PRE_W-1:0] div_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else if (div_q == prescale_div) begin
      div_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      div_q  <= div_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  // R3: with a divide of zero every enabled cycle yields a tick
  p_tick_every_r3: assert property (@(posedge clk) disable iff (rst)
    (en && prescale_div == '0) |=> tick_q);

  // R9: disabled means no tick
  p_tick_off_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick_q);

endmodule

// File: rtl/scl_guard_lowcnt.sv
module scl_guard_lowcnt
  import scl_guard_pkg::*;
#(
  parameter int             CNT_W      = 16,
  parameter logic [CNT_W-1:0] WARN_TICKS = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             scl_filt,
  input  logic [CNT_W-1:0] limit,
  input  logic             clr_sticky,
  output guard_flags_t     flags
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             line_low;
  logic             over_limit;
  logic             fire;
  logic             fired_q;
  logic             timeout_q, bus_reset_q, sticky_q, warn_q;

  assign line_low = (scl_filt != SCL_IDLE_LVL);

  // Saturating low-time counter, cleared whenever the line is high.
  always_ff @(posedge clk) begin
    if (rst || !en || !line_low) cnt_q <= '0;
    else if (tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign over_limit = en && line_low && (cnt_q >= limit);
  assign fire       = over_limit && !fired_q;

  // Remembers that this low period already produced its reset pulse.
  always_ff @(posedge clk) begin
    if (rst || !en || !line_low) fired_q <= 1'b0;
    else if (fire)               fired_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timeout_q   <= 1'b0;
      bus_reset_q <= 1'b0;
      sticky_q    <= 1'b0;
      warn_q      <= 1'b0;
    end else begin
      timeout_q   <= over_limit;
      bus_reset_q <= fire;
      sticky_q    <= (sticky_q && !clr_sticky) || fire;
      warn_q      <= en && line_low && (cnt_q >= WARN_TICKS);
    end
  end

  assign flags = '{timeout: timeout_q, bus_reset: bus_reset_q,
                   sticky: sticky_q, warn: warn_q};

  // R3: the count only holds, steps by one, or clears
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_q == '0 || cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  // R5: the reset request never lasts two cycles
  p_pulse_once_r5: assert property (@(posedge clk) disable iff (rst)
    bus_reset_q |=> !bus_reset_q);

  // R5: the reset request coincides with the live timeout flag
  p_pulse_flag_r5: assert property (@(posedge clk) disable iff (rst)
    bus_reset_q |-> timeout_q);

  // R6: the sticky bit only rises with a reset request
  p_sticky_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sticky_q) |-> bus_reset_q);

  // R9: disabling clears the count and blocks the flags
  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0 && !timeout_q && !bus_reset_q && !warn_q));

  // R10: a full counter stays full while the line stays low
  p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && en && line_low) |=> cnt_q == CNT_MAX);

endmodule

// File: rtl/scl_guard.sv
module scl_guard
  import scl_guard_pkg::*;
#(
  parameter int               CNT_W       = 16,
  parameter int               PRE_W       = 8,
  parameter int               SYNC_STAGES = 2,
  parameter int               FILT_LEN    = 3,
  parameter logic [CNT_W-1:0] WARN_TICKS  = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             scl_raw,
  input  logic [PRE_W-1:0] prescale_div,
  input  logic [CNT_W-1:0] limit,
  input  logic             clr_sticky,
  output logic             timeout_o,
  output logic             bus_reset_o,
  output logic             sticky_o,
  output logic             warn_o
);

  logic         scl_filt;
  logic         tick;
  guard_flags_t flags;

  scl_guard_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_filter (
    .clk     (clk),
    .rst     (rst),
    .scl_in  (scl_raw),
    .scl_filt(scl_filt)
  );

  scl_guard_tick #(
    .PRE_W(PRE_W)
  ) u_tick (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .prescale_div(prescale_div),
    .tick        (tick)
  );

  scl_guard_lowcnt #(
    .CNT_W     (CNT_W),
    .WARN_TICKS(WARN_TICKS)
  ) u_lowcnt (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .tick      (tick),
    .scl_filt  (scl_filt),
    .limit     (limit),
    .clr_sticky(clr_sticky),
    .flags     (flags)
  );

  assign timeout_o   = flags.timeout;
  assign bus_reset_o = flags.bus_reset;
  assign sticky_o    = flags.sticky;
  assign warn_o      = flags.warn;

  // R1: no output is active in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!timeout_o && !bus_reset_o && !sticky_o && !warn_o));

endmodule

// File: tb/sim_scl_guard.sv
module sim_scl_guard;

  localparam int CNT_W = 12;
  localparam int PRE_W = 8;
  localparam int WARN  = 100;

  logic             clk = 1'b0;
  logic             rst;
  logic             en;
  logic             scl_raw;
  logic [PRE_W-1:0] prescale_div;
  logic [CNT_W-1:0] limit;
  logic             clr_sticky;
  logic             timeout_o, bus_reset_o, sticky_o, warn_o;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses   = 0;

  always #4 clk = ~clk;

  scl_guard #(
    .CNT_W     (CNT_W),
    .PRE_W     (PRE_W),
    .WARN_TICKS(CNT_W'(WARN))
  ) u0 (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .scl_raw     (scl_raw),
    .prescale_div(prescale_div),
    .limit       (limit),
    .clr_sticky  (clr_sticky),
    .timeout_o   (timeout_o),
    .bus_reset_o (bus_reset_o),
    .sticky_o    (sticky_o),
    .warn_o      (warn_o)
  );

  // Count reset requests shortly after each rising edge.
  always @(posedge clk) begin
    #1;
    if (!rst && bus_reset_o) pulses++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_timeout(input int low_cycles, input int lim);
    return (low_cycles > lim) ? 1 : 0;
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hold_low(input int d);
    scl_raw = 1'b0;
    wait_n(d);
    scl_raw = 1'b1;
    wait_n(12);
  endtask

  task automatic clear_sticky();
    clr_sticky = 1'b1;
    wait_n(1);
    clr_sticky = 1'b0;
    wait_n(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int p0;
    int unsigned seed;
    seed = $urandom(32'h5EED);
    rst = 1'b1; en = 1'b1; scl_raw = 1'b1; prescale_div = '0;
    limit = 12'd20; clr_sticky = 1'b0;
    wait_n(5);
    chk("R1 timeout in reset", timeout_o, 0);
    chk("R1 pulse in reset", bus_reset_o, 0);
    chk("R1 sticky in reset", sticky_o, 0);
    chk("R1 warn in reset", warn_o, 0);
    rst = 1'b0;
    wait_n(3);

    // R4, R5, R6: exact timing of the timeout for limit 20
    p0 = pulses;
    scl_raw = 1'b0;
    wait_n(26);
    chk("R4 timeout one cycle early", timeout_o, 0);
    chk("R5 pulse one cycle early", bus_reset_o, 0);
    wait_n(1);
    chk("R4 timeout due at limit+7", timeout_o, 1);
    chk("R5 pulse due at limit+7", bus_reset_o, 1);
    chk("R6 sticky set with pulse", sticky_o, 1);
    wait_n(1);
    chk("R5 pulse lasts one cycle", bus_reset_o, 0);
    wait_n(30);
    chk("R4 timeout held while low", timeout_o, 1);
    chk("R5 single pulse per event", pulses - p0, 1);
    scl_raw = 1'b1;
    wait_n(8);
    chk("R4 timeout drops after release", timeout_o, 0);
    wait_n(10);
    chk("R6 sticky held after release", sticky_o, 1);
    clear_sticky();
    chk("R6 sticky cleared", sticky_o, 0);

    // R7: warning timing with a limit above the warning point
    limit = 12'd300;
    scl_raw = 1'b0;
    wait_n(WARN + 6);
    chk("R7 warn one cycle early", warn_o, 0);
    wait_n(1);
    chk("R7 warn due at WARN+7", warn_o, 1);
    chk("R7 no timeout below limit", timeout_o, 0);
    scl_raw = 1'b1;
    wait_n(10);
    chk("R7 warn drops after release", warn_o, 0);

    // R2: a two-cycle glitch is rejected, a three-cycle low is accepted
    limit = 12'd1;
    p0 = pulses;
    hold_low(2);
    chk("R2 glitch ignored sticky", sticky_o, 0);
    chk("R2 glitch ignored pulse", pulses - p0, 0);
    hold_low(3);
    chk("R2 three-cycle low accepted", sticky_o, 1);
    clear_sticky();

    // R8: separate short lows do not accumulate
    limit = 12'd50;
    scl_raw = 1'b0; wait_n(40);
    scl_raw = 1'b1; wait_n(10);
    scl_raw = 1'b0; wait_n(40);
    scl_raw = 1'b1; wait_n(12);
    chk("R8 no accumulation", sticky_o, 0);

    // R9: disabled block ignores a long low
    limit = 12'd20;
    p0 = pulses;
    en = 1'b0;
    scl_raw = 1'b0;
    wait_n(300);
    chk("R9 timeout while disabled", timeout_o, 0);
    chk("R9 warn while disabled", warn_o, 0);
    scl_raw = 1'b1;
    wait_n(12);
    en = 1'b1;
    wait_n(2);
    chk("R9 no pulse while disabled", pulses - p0, 0);
    chk("R9 no sticky while disabled", sticky_o, 0);
    // disabling mid-low clears the count
    limit = 12'd50;
    scl_raw = 1'b0; wait_n(40);
    en = 1'b0; wait_n(1);
    en = 1'b1; wait_n(40);
    scl_raw = 1'b1; wait_n(12);
    chk("R9 disable restarts count", sticky_o, 0);

    // R3: prescaler, one tick every 4 cycles
    prescale_div = 8'd3;
    limit = 12'd10;
    hold_low(30);
    chk("R3 prescaled short low", sticky_o, 0);
    hold_low(60);
    chk("R3 prescaled long low", sticky_o, 1);
    clear_sticky();
    prescale_div = '0;

    // R10: saturation at the counter maximum
    limit = {CNT_W{1'b1}};
    p0 = pulses;
    scl_raw = 1'b0;
    wait_n(4300);
    chk("R10 timeout held at saturation", timeout_o, 1);
    chk("R10 one pulse at saturation", pulses - p0, 1);
    scl_raw = 1'b1;
    wait_n(12);
    clear_sticky();

    // R3, R5: random low lengths around random limits
    for (int t = 0; t < 20; t++) begin
      int lim;
      int d;
      int e;
      lim = 5 + int'($urandom_range(55));
      d   = (t % 4 == 0) ? lim + (t % 8 == 0 ? 0 : 1) : 3 + int'($urandom_range(2 * lim));
      e   = exp_timeout(d, lim);
      limit = CNT_W'(lim);
      p0 = pulses;
      hold_low(d);
      chk("R3 random low sticky", sticky_o, e);
      chk("R5 random low pulse count", pulses - p0, e);
      clear_sticky();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule